// File: doc/BRIEF.md
# Statistical Operation Sample Selector

This block watches a stream of issued operations, one possible operation per clock, and picks one of them for profiling each time a programmable count of eligible operations has gone by. The chosen operation is announced with a one-cycle select pulse and its tag. The block then follows it as the single sampled operation in flight until the pipeline reports that it has completed. Building the record, filtering it and storing it belong to the logic around this block. This block only decides which operation is sampled and keeps the statistics a profiler needs to judge how reliable its samples are.

The countdown runs on eligible operations, not on clock cycles. It reloads every time it expires. An interval of zero selects a fixed minimum interval. When jitter is enabled, the low bits of a free-standing pseudo-random sequence are added to each reload value. This stops the sample points from locking onto the period of a program loop. If the countdown expires while an earlier sample is still in flight, that selection is dropped and counted as a collision. A second counter records the size of the population that was sampled from.

Top module: `opsamp_top`

## Requirements
- R1: While `smp_en` is high, the countdown drops by one for each cycle with `op_valid` high. With an effective interval of N, the Nth eligible operation after a reload is the one selected. The countdown reloads on every expiry.
- R2: A value of zero on `interval` gives an effective interval equal to the parameter MIN_INTERVAL (default 16).
- R3: With `jitter_en` high, each reload value is the effective interval plus the low JW bits (default 8) of a 16-bit LFSR. The LFSR starts at 16'hACE1 after reset. On every expiry it shifts left by one, taking into bit 0 the XOR of bits 15, 13, 12 and 10. With `jitter_en` low, nothing is added.
- R4: A selection raises `sel_pulse` for exactly one cycle, in the cycle after the selected operation was presented. In that cycle `sel_tag` shows that operation's `op_tag`. A selection happens only when no sample is in flight.
- R5: `busy` rises together with `sel_pulse` and falls in the cycle after `op_done` is seen. `op_done` has no effect while idle. If `op_done` arrives in the same cycle as a new selection, the block stays busy.
- R6: An expiry that occurs while `busy` is high produces no pulse, raises `coll_cnt` by one in the next cycle, and still reloads the countdown.
- R7: `pop_cnt` rises by one for each cycle with `smp_en` and `op_valid` both high. While `smp_en` is low, operations are neither counted nor selected, and the countdown is held at the current reload value.
- R8: `cnt_clr` sets both counters to zero in the next cycle. It takes priority over a simultaneous increment and does not affect `busy` or the countdown.
- R9: Both counters stop at all-ones. A reload sum larger than the largest interval value saturates at that value (all-ones of IW bits).
- R10: After reset `sel_pulse` and `busy` are low, `sel_tag` is zero, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Global sampling enable |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| op_valid | input | 1 | An eligible operation is issued this cycle |
| op_tag | input | TAGW | Identifier of the operation issued this cycle |
| op_done | input | 1 | The tracked sampled operation has completed |
| interval | input | IW | Sampling interval in operations; zero selects the minimum |
| jitter_en | input | 1 | Add pseudo-random perturbation to each reload |
| sel_pulse | output | 1 | One-cycle pulse marking a selection |
| sel_tag | output | TAGW | Tag of the most recently selected operation |
| busy | output | 1 | A sampled operation is in flight |
| coll_cnt | output | CNT_W | Dropped selections, saturating |
| pop_cnt | output | CNT_W | Eligible operations seen, saturating |

## Verification
The hardest case to reach from the ports is an expiry whose reload sum overflows the interval width. Reaching it requires the largest interval value with jitter on, followed by about a thousand eligible operations, so a random stream never gets there. A directed phase drives exactly that case. If the sum wrapped instead of saturating, many selections would appear where exactly one is expected. Counter saturation is reached by a directed phase with an interval of one and no completions, so that every operation expires and collides. A seeded random phase then mixes enables, clears, interval changes and completions that land in the same cycle as a selection. A bench model tracks the LFSR and the countdown and checks every output in every cycle.

// File: rtl/opsamp_pkg.sv
package opsamp_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_BUSY = 1'b1
  } trk_state_e;

  localparam int          LFSR_W    = 16;
  // feedback taps at bit indices 15, 13, 12, 10 (maximal length)
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/opsamp_lfsr.sv
module opsamp_lfsr #(
  parameter int           W    = opsamp_pkg::LFSR_W,
  parameter logic [W-1:0] TAPS = opsamp_pkg::LFSR_TAPS,
  parameter logic [W-1:0] SEED = opsamp_pkg::LFSR_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  timeunit 1ns;
  timeprecision 100ps;

  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end
endmodule

// File: rtl/opsamp_interval.sv
module opsamp_interval #(
  parameter int IW           = 16,
  parameter int JW           = 8,
  parameter int MIN_INTERVAL = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          op_valid,
  input  logic          jitter_en,
  input  logic [IW-1:0] interval,
  input  logic [JW-1:0] jit,
  output logic          expire
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int          SW    = IW + 1;
  localparam logic [IW-1:0] MIN_V = IW'(MIN_INTERVAL);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] base;
  logic [JW-1:0] jit_m;
  logic [SW-1:0] sum;
  logic [IW-1:0] reload;

  always_comb begin
    base   = (interval == '0) ? MIN_V : interval;
    jit_m  = jitter_en ? jit : '0;
    sum    = {1'b0, base} + {{(SW-JW){1'b0}}, jit_m};
    reload = sum[IW] ? '1 : sum[IW-1:0];
  end

  assign expire = smp_en && op_valid && (cnt_q <= IW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= MIN_V;
    end else if (!smp_en) begin
      cnt_q <= reload;
    end else if (op_valid) begin
      cnt_q <= expire ? reload : cnt_q - IW'(1);
    end
  end
endmodule

// File: rtl/opsamp_tracker.sv
module opsamp_tracker #(
  parameter int TAGW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            expire,
  input  logic [TAGW-1:0] op_tag,
  input  logic            op_done,
  output logic            sel_pulse,
  output logic [TAGW-1:0] sel_tag,
  output logic            busy,
  output logic            coll_strobe
);
  timeunit 1ns;
  timeprecision 100ps;
  import opsamp_pkg::*;

  trk_state_e state_q;
  logic       take;

  assign busy        = (state_q == TRK_BUSY);
  assign take        = expire && !busy;
  assign coll_strobe = expire && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TRK_IDLE;
      sel_pulse <= 1'b0;
      sel_tag   <= '0;
    end else begin
      sel_pulse <= take;
      if (take) begin
        sel_tag <= op_tag;
        state_q <= TRK_BUSY;
      end else if (op_done) begin
        state_q <= TRK_IDLE;
      end
    end
  end
endmodule

// File: rtl/opsamp_satcnt.sv
module opsamp_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != '1)) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/opsamp_top.sv
module opsamp_top #(
  parameter int IW           = 16,
  parameter int JW           = 8,
  parameter int MIN_INTERVAL = 16,
  parameter int TAGW         = 8,
  parameter int CNT_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             cnt_clr,
  input  logic             op_valid,
  input  logic [TAGW-1:0]  op_tag,
  input  logic             op_done,
  input  logic [IW-1:0]    interval,
  input  logic             jitter_en,
  output logic             sel_pulse,
  output logic [TAGW-1:0]  sel_tag,
  output logic             busy,
  output logic [CNT_W-1:0] coll_cnt,
  output logic [CNT_W-1:0] pop_cnt
);
  timeunit 1ns;
  timeprecision 100ps;
  import opsamp_pkg::*;

  localparam int NCNT = 2;  // index 0: population, index 1: collisions

  logic              expire;
  logic              coll_strobe;
  logic [LFSR_W-1:0] lfsr_q;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  opsamp_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .step  (expire),
    .state (lfsr_q)
  );

  opsamp_interval #(.IW(IW), .JW(JW), .MIN_INTERVAL(MIN_INTERVAL)) u_interval (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .op_valid  (op_valid),
    .jitter_en (jitter_en),
    .interval  (interval),
    .jit       (lfsr_q[JW-1:0]),
    .expire    (expire)
  );

  opsamp_tracker #(.TAGW(TAGW)) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .expire      (expire),
    .op_tag      (op_tag),
    .op_done     (op_done),
    .sel_pulse   (sel_pulse),
    .sel_tag     (sel_tag),
    .busy        (busy),
    .coll_strobe (coll_strobe)
  );

  assign cnt_inc = {coll_strobe, smp_en & op_valid};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    opsamp_satcnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr),
      .inc (cnt_inc[g]),
      .cnt (cnt_val[g])
    );
  end

  assign pop_cnt  = cnt_val[0];
  assign coll_cnt = cnt_val[1];
endmodule

// File: rtl/opsamp_checker.sv
module opsamp_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             op_done,
  input logic             sel_pulse,
  input logic             busy,
  input logic [CNT_W-1:0] coll_cnt,
  input logic [CNT_W-1:0] pop_cnt
);
  timeunit 1ns;
  timeprecision 100ps;

  assert_sel_single_R4: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |=> !sel_pulse);

  assert_sel_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |-> !$past(busy));

  assert_busy_with_sel_R5: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |-> busy);

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(op_done) && $past(busy)) |-> !busy);

  assert_coll_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(cnt_clr) |-> (coll_cnt >= $past(coll_cnt)));

  assert_coll_excludes_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_clr) && (coll_cnt != $past(coll_cnt))) |-> !sel_pulse);

  assert_pop_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(cnt_clr) |-> (pop_cnt >= $past(pop_cnt)));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clr) |-> ((coll_cnt == '0) && (pop_cnt == '0)));
endmodule

bind opsamp_top opsamp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_clr   (cnt_clr),
  .op_done   (op_done),
  .sel_pulse (sel_pulse),
  .busy      (busy),
  .coll_cnt  (coll_cnt),
  .pop_cnt   (pop_cnt)
);

// File: tb/opsamp_top_test.sv
module opsamp_top_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IW    = 10;
  localparam int JW    = 8;
  localparam int MINV  = 16;
  localparam int TAGW  = 6;
  localparam int CW    = 8;
  localparam int MAXIV = (1 << IW) - 1;
  localparam int MAXC  = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            smp_en = 1'b0;
  logic            cnt_clr = 1'b0;
  logic            op_valid = 1'b0;
  logic [TAGW-1:0] op_tag = '0;
  logic            op_done = 1'b0;
  logic [IW-1:0]   interval = '0;
  logic            jitter_en = 1'b0;
  logic            sel_pulse;
  logic [TAGW-1:0] sel_tag;
  logic            busy;
  logic [CW-1:0]   coll_cnt;
  logic [CW-1:0]   pop_cnt;

  opsamp_top #(.IW(IW), .JW(JW), .MIN_INTERVAL(MINV), .TAGW(TAGW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .cnt_clr(cnt_clr),
    .op_valid(op_valid), .op_tag(op_tag), .op_done(op_done),
    .interval(interval), .jitter_en(jitter_en),
    .sel_pulse(sel_pulse), .sel_tag(sel_tag), .busy(busy),
    .coll_cnt(coll_cnt), .pop_cnt(pop_cnt)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int sel_seen = 0;
  bit finished = 0;

  // reference model state
  int          m_cnt;
  logic [15:0] m_lfsr;
  bit          m_busy, m_sel;
  logic [TAGW-1:0] m_tag;
  int          m_coll, m_pop;

  function automatic int reload_f(int iv, bit je, logic [15:0] lf);
    int b = (iv == 0) ? MINV : iv;
    int s = b + (je ? int'(lf[JW-1:0]) : 0);
    return (s > MAXIV) ? MAXIV : s;
  endfunction

  task automatic model_edge();
    int rl;
    bit ex, take, coll;
    if (rst) begin
      m_cnt = MINV; m_lfsr = 16'hACE1; m_busy = 0; m_sel = 0;
      m_tag = '0; m_coll = 0; m_pop = 0;
    end else begin
      rl   = reload_f(int'(interval), jitter_en, m_lfsr);
      ex   = smp_en && op_valid && (m_cnt <= 1);
      take = ex && !m_busy;
      coll = ex && m_busy;
      m_sel = take;
      if (take) m_tag = op_tag;
      if (take) m_busy = 1; else if (op_done) m_busy = 0;
      if (cnt_clr) begin
        m_coll = 0; m_pop = 0;
      end else begin
        if (coll && m_coll < MAXC) m_coll++;
        if (smp_en && op_valid && m_pop < MAXC) m_pop++;
      end
      if (!smp_en) m_cnt = rl;
      else if (op_valid) m_cnt = ex ? rl : m_cnt - 1;
      if (ex) m_lfsr = {m_lfsr[14:0], ^(m_lfsr & 16'hB400)};
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " R4"}, "sel_pulse", int'(sel_pulse), int'(m_sel));
    if (m_sel) chk({req, " R4"}, "sel_tag", int'(sel_tag), int'(m_tag));
    chk({req, " R5"}, "busy", int'(busy), int'(m_busy));
    chk({req, " R6"}, "coll_cnt", int'(coll_cnt), m_coll);
    chk({req, " R7"}, "pop_cnt", int'(pop_cnt), m_pop);
    if (sel_pulse) sel_seen++;
  endtask

  task automatic step(input bit v, input logic [TAGW-1:0] tg, input bit d, input string req);
    @(negedge clk);
    op_valid = v; op_tag = tg; op_done = d;
    @(posedge clk);
    model_edge();
    #2;
    compare_all(req);
  endtask

  task automatic prep(input int iv, input bit je);
    smp_en = 0; cnt_clr = 0; interval = IW'(iv); jitter_en = je;
    step(0, '0, 1, "prep");
    cnt_clr = 1;
    step(0, '0, 0, "prep R8");
    cnt_clr = 0; smp_en = 1;
    sel_seen = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int pop_before;
    void'($urandom(32'd20240611));
    // reset
    for (int i = 0; i < 5; i++) step(0, '0, 0, "R10");
    rst = 0;
    step(0, '0, 0, "R10");
    chk("R10", "sel_pulse after reset", int'(sel_pulse), 0);
    chk("R10", "busy after reset", int'(busy), 0);
    chk("R10", "sel_tag after reset", int'(sel_tag), 0);
    chk("R10", "coll_cnt after reset", int'(coll_cnt), 0);
    chk("R10", "pop_cnt after reset", int'(pop_cnt), 0);

    // R1: interval 7, completions always ready
    prep(7, 0);
    for (int i = 0; i < 70; i++) step(1, TAGW'(i), 1, "R1");
    chk("R1", "selections with interval 7 over 70 ops", sel_seen, 10);
    chk("R7", "population after 70 ops", int'(pop_cnt), 70);

    // R2: zero interval uses the minimum
    prep(0, 0);
    for (int i = 0; i < 64; i++) step(1, TAGW'(i + 3), 1, "R2");
    chk("R2", "selections with zero interval over 64 ops", sel_seen, 4);

    // R6: no completion, every later expiry collides
    prep(3, 0);
    for (int i = 0; i < 30; i++) step(1, TAGW'(i), 0, "R6");
    chk("R6", "selections while stuck busy", sel_seen, 1);
    chk("R6", "collision count", int'(coll_cnt), 9);
    chk("R5", "busy held without completion", int'(busy), 1);
    step(0, '0, 1, "R5");
    chk("R5", "busy after completion", int'(busy), 0);

    // R5: completion in the selection cycle keeps busy
    prep(2, 0);
    step(1, 6'd11, 0, "R5");
    step(1, 6'd22, 1, "R5");
    chk("R5", "busy after done with new selection", int'(busy), 1);
    chk("R4", "tag of selected op", int'(sel_tag), 22);
    step(0, '0, 1, "R5");

    // R7: disabled operations ignored
    pop_before = int'(pop_cnt);
    smp_en = 0; sel_seen = 0;
    for (int i = 0; i < 10; i++) step(1, TAGW'(i), 1, "R7");
    chk("R7", "population while disabled", int'(pop_cnt), pop_before);
    chk("R7", "selections while disabled", sel_seen, 0);

    // R8: clear beats a simultaneous increment
    smp_en = 1; cnt_clr = 1;
    step(1, '0, 1, "R8");
    cnt_clr = 0;
    chk("R8", "population after clear with op", int'(pop_cnt), 0);

    // R3: jitter stretches the gaps
    prep(20, 1);
    for (int i = 0; i < 400; i++) step(1, TAGW'(i), 1, "R3");
    chk("R3", "jitter yields some selections", int'(sel_seen > 0), 1);
    chk("R3", "jitter lengthens gaps", int'(sel_seen <= 15), 1);

    // R9: counter saturation
    prep(1, 0);
    for (int i = 0; i < 300; i++) step(1, TAGW'(i), 0, "R9");
    chk("R9", "population saturates", int'(pop_cnt), MAXC);
    chk("R9", "collisions saturate", int'(coll_cnt), MAXC);
    step(0, '0, 1, "R9");

    // R9: reload sum saturates at the largest interval
    prep(MAXIV, 1);
    for (int i = 0; i < 1030; i++) step(1, TAGW'(i), 1, "R9");
    chk("R9", "single selection with saturated reload", sel_seen, 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      smp_en  = ($urandom_range(0, 15) != 0);
      cnt_clr = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 63) == 0) interval = IW'($urandom_range(0, 12));
      if ($urandom_range(0, 127) == 0) jitter_en = ~jitter_en;
      step(bit'($urandom_range(0, 3) != 0), TAGW'($urandom), bit'($urandom_range(0, 5) == 0), "R1 R3");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule